// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block produces a pulse-width modulated output from its own timebase. A prescaler divides the clock, and a timer counts the divided ticks from zero up to a programmable period value before it restarts. The output is high at the start of every period and drops once the timer reaches the active duty value. Boundary duty values therefore give a constant low output, a constant high output, or a single low count.

Software writes a secondary duty register whenever it likes. That value moves into the active duty register only when the timer completes a period, so a new duty never cuts a pulse short. The active duty register can be written directly only while no PWM mode is selected. This seeds the duty of the first period. In the fault-aware mode, an external fault input forces the output low and latches a sticky flag. The flag stays set until software rewrites the control register. One-cycle pulses report each period match and each new fault.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: With period register value N and prescale divide D, `match_irq` pulses high for one cycle every (N+1)*D clock cycles, and the timer restarts from zero on that match.
- R2: Control bits [4:3] select the prescale divide: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8. Each timer count lasts that many clock cycles.
- R3: In a PWM mode with active duty value K (0 < K <= period), `pwm_out` is high for the first K timer counts of each period and low for the rest.
- R4: An active duty value of 0 keeps `pwm_out` low for the whole period.
- R5: An active duty value greater than the period value keeps `pwm_out` high for the whole period.
- R6: An active duty value equal to the period value gives exactly one low timer count per period, the last one.
- R7: A write to the secondary duty register (address 1) does not change the current period. Its value takes effect from the next period start.
- R8: The active duty register (address 2) accepts writes only when control bits [2:0] are not 6 or 7. Its value sets the duty of the first period after enabling. In PWM modes, writes to it are ignored.
- R9: Control bit 7 enables the timebase. While it is clear, the timer and prescaler hold at zero and no match occurs. Setting it starts the first period at count zero. Address 0 is the period register and address 3 is the control register.
- R10: In mode 7, a high `fault_in` sampled at a clock edge sets `fault_sticky` and forces `pwm_out` low from that edge. `fault_irq` pulses for exactly one cycle. Mode 6 ignores `fault_in`.
- R11: Any write to the control register clears `fault_sticky`, and PWM output resumes.
- R12: After reset, `pwm_out`, `match_irq`, `fault_irq` and `fault_sticky` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 secondary duty, 2 active duty, 3 control |
| wr_data | input | W | Write data |
| fault_in | input | 1 | External fault request |
| pwm_out | output | 1 | PWM waveform |
| match_irq | output | 1 | One-cycle pulse on each period match |
| fault_irq | output | 1 | One-cycle pulse when a fault is latched |
| fault_sticky | output | 1 | Latched fault flag |

## Verification
The checker assumes that the register write port carries one write per cycle. It also assumes that `fault_in` is already synchronous to `clk`, since the block samples it directly with no synchronizer. The latch-timing property assumes that the mode does not leave PWM in the same cycle as an active duty write. The bench drives every write and every fault change on the falling edge, so each input is stable for a full cycle around the rising edge. It reconfigures the block only with the timebase disabled, by first writing a control value with bit 7 clear.

// File: rtl/pwm_dbuf_gen.sv
`timescale 1ns/1ps
module pwm_dbuf_gen #(
  parameter int W   = 16,
  parameter int PSW = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         fault_in,
  output logic         pwm_out,
  output logic         match_irq,
  output logic         fault_irq,
  output logic         fault_sticky
);
  localparam int PCW = (1 << PSW) - 1;
  localparam logic [2:0] MODE_PWM   = 3'b110;
  localparam logic [2:0] MODE_PWM_F = 3'b111;

  logic [W-1:0]   per_q, sec_q, act_q, tmr_q;
  logic [2:0]     mode_q;
  logic [PSW-1:0] ps_q;
  logic           en_q;
  logic [PCW-1:0] pre_q, pre_lim;
  logic           flt_q, mirq_q, firq_q;

  wire pwm_mode = (mode_q == MODE_PWM) || (mode_q == MODE_PWM_F);
  wire wr_per   = wr_en && (wr_addr == 2'd0);
  wire wr_sec   = wr_en && (wr_addr == 2'd1);
  wire wr_act   = wr_en && (wr_addr == 2'd2) && !pwm_mode;
  wire wr_ctl   = wr_en && (wr_addr == 2'd3);

  assign pre_lim = PCW'((1 << ps_q) - 1);

  wire tick = en_q && (pre_q == pre_lim);
  wire wrap = tick && (tmr_q >= per_q);
  wire fset = (mode_q == MODE_PWM_F) && fault_in && !flt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= '0;
      sec_q  <= '0;
      act_q  <= '0;
      mode_q <= '0;
      ps_q   <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_per) per_q <= wr_data;
      if (wr_sec) sec_q <= wr_data;
      if (wrap)        act_q <= sec_q;
      else if (wr_act) act_q <= wr_data;
      if (wr_ctl) begin
        mode_q <= wr_data[2:0];
        ps_q   <= wr_data[3 +: PSW];
        en_q   <= wr_data[7];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_q) begin
      pre_q <= '0;
      tmr_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      tmr_q <= wrap ? '0 : tmr_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_q  <= 1'b0;
      mirq_q <= 1'b0;
      firq_q <= 1'b0;
    end else begin
      mirq_q <= wrap;
      firq_q <= fset && !wr_ctl;
      if (wr_ctl)    flt_q <= 1'b0;
      else if (fset) flt_q <= 1'b1;
    end
  end

  assign pwm_out      = pwm_mode && !flt_q && (tmr_q < act_q);
  assign match_irq    = mirq_q;
  assign fault_irq    = firq_q;
  assign fault_sticky = flt_q;
endmodule

// File: rtl/pwm_dbuf_gen_sva.sv
`timescale 1ns/1ps
module pwm_dbuf_gen_sva #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pwm_out,
  input logic         match_irq,
  input logic         fault_irq,
  input logic         fault_sticky,
  input logic [W-1:0] tmr,
  input logic [W-1:0] act,
  input logic         en,
  input logic         pwm_mode
);
  assert_match_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |-> (tmr == '0));

  assert_zero_duty_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |-> !pwm_out);

  assert_latch_at_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act) && $past(pwm_mode)) |-> match_irq);

  assert_idle_timer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!en) && !en) |-> (tmr == '0));

  assert_fault_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_sticky |-> !pwm_out);

  assert_fault_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> fault_sticky);

  assert_fault_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |=> !fault_irq);
endmodule

bind pwm_dbuf_gen pwm_dbuf_gen_sva #(.W(W)) u_sva (
  .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .match_irq(match_irq),
  .fault_irq(fault_irq), .fault_sticky(fault_sticky), .tmr(tmr_q),
  .act(act_q), .en(en_q), .pwm_mode(pwm_mode)
);

// File: tb/tb_pwm_dbuf_gen.sv
`timescale 1ns/1ps
module tb_pwm_dbuf_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        fault_in = 1'b0;
  logic        pwm_out, match_irq, fault_irq, fault_sticky;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwm_dbuf_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fault_in(fault_in), .pwm_out(pwm_out),
    .match_irq(match_irq), .fault_irq(fault_irq), .fault_sticky(fault_sticky)
  );

  localparam int NV = 8;
  localparam int VP[NV] = '{9, 9, 9,  9, 5, 3, 4, 2};
  localparam int VD[NV] = '{4, 0, 12, 9, 2, 3, 1, 10};
  localparam int VS[NV] = '{0, 0, 0,  0, 1, 2, 3, 1};
  localparam int VH[NV] = '{4, 0, 10, 9, 4, 12, 8, 6};

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int p, input int d, input int ps, input int mode);
    wr(3, 0);
    wr(0, p);
    wr(1, d);
    wr(2, d);
    wr(3, 32'h80 | (ps << 3) | mode);
  endtask

  task automatic measure(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      hi += int'(pwm_out);
      @(negedge clk);
    end
  endtask

  task automatic wait_match();
    for (int i = 0; i < 200 && !match_irq; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int h, h2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 pwm_out", int'(pwm_out), 0);
    chk("R12 match_irq", int'(match_irq), 0);
    chk("R12 fault_irq", int'(fault_irq), 0);
    chk("R12 fault_sticky", int'(fault_sticky), 0);

    for (int v = 0; v < NV; v++) begin
      cfg(VP[v], VD[v], VS[v], 6);
      measure((VP[v] + 1) * (1 << VS[v]), h);
      chk($sformatf("R3/R4/R5/R6/R2 vector %0d high", v), h, VH[v]);
      chk($sformatf("R1/R2 vector %0d match", v), int'(match_irq), 1);
      @(negedge clk);
      chk($sformatf("R1 vector %0d pulse width", v), int'(match_irq), 0);
    end

    // R7 secondary write mid-period, R8 ignored active write
    cfg(9, 3, 0, 6);
    measure(10, h);
    chk("R3 first period", h, 3);
    measure(4, h);
    wr(1, 7);
    measure(5, h2);
    chk("R7 current period unchanged", h + h2, 3);
    chk("R7 match", int'(match_irq), 1);
    measure(10, h);
    chk("R7 next period uses new duty", h, 7);
    h = int'(pwm_out);
    wr(2, 1);
    measure(9, h2);
    chk("R8 active write ignored in PWM mode", h + h2, 7);

    // R8 initial active duty sets the first period
    wr(3, 0);
    wr(0, 9);
    wr(1, 2);
    wr(2, 6);
    wr(3, 32'h86);
    measure(10, h);
    chk("R8 first period from active", h, 6);
    measure(10, h);
    chk("R7 second period from secondary", h, 2);

    // R9 disable holds the timebase
    wr(3, 6);
    repeat (2) @(negedge clk);
    h = 0;
    for (int i = 0; i < 30; i++) begin
      h += int'(match_irq);
      @(negedge clk);
    end
    chk("R9 no match while disabled", h, 0);
    chk("R9 timer held at zero", int'(pwm_out), 1);

    // R10 fault mode
    cfg(9, 5, 0, 7);
    measure(1, h);
    fault_in = 1'b1;
    @(negedge clk);
    chk("R10 output forced low", int'(pwm_out), 0);
    chk("R10 sticky set", int'(fault_sticky), 1);
    chk("R10 fault pulse", int'(fault_irq), 1);
    fault_in = 1'b0;
    @(negedge clk);
    chk("R10 fault pulse ends", int'(fault_irq), 0);
    measure(20, h);
    chk("R10 output stays low", h, 0);
    chk("R10 sticky holds", int'(fault_sticky), 1);
    wr(3, 32'h87);
    chk("R11 sticky cleared", int'(fault_sticky), 0);
    wait_match();
    measure(10, h);
    chk("R11 PWM resumes", h, 5);

    // R10 mode 6 ignores fault
    cfg(9, 5, 0, 6);
    fault_in = 1'b1;
    measure(10, h);
    chk("R10 mode 6 ignores fault", h, 5);
    chk("R10 mode 6 no sticky", int'(fault_sticky), 0);
    fault_in = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule